// File: doc/BRIEF.md
# PLL Lock Qualification Controller

This block brings a digital PLL into service after a start request. It works out the frequency window that the PLL tunes against from the host clock rate given in MHz. It then presents that window, with the tuning-enable bit set, as a 32-bit limit word. After that it watches the PLL's lock indicator.

Each calibration attempt has two phases. First the controller looks for lock, sampling the indicator once per fixed spacing of cycles, up to a bounded number of samples. Once it sees lock, the lock must then stay high on every clock for a qualification window. A single low sample inside that window ends the attempt.

A failed attempt rewrites the limit word with tuning disabled and starts again, up to a bounded number of attempts. The run ends in one of two ways:
- An attempt qualifies: the controller clears tuning and raises `ready`.
- Every attempt fails: the controller raises `fail`.

Either flag stays up until the next start request.

Top module: `pll_lock_qual`

## Requirements
- R1: While `rst` is high and after it, until the first `start`, `lim_word` is zero, `tune_en` is 0 and both `ready` and `fail` are 0.
- R2: At the clock edge where `start` is high, the block samples `clk_mhz` (0 to 255). From the next cycle, `lim_word[15:0]` holds floor(`clk_mhz`*48/66) with bit 8 ORed in as the tuning-enable bit, and `lim_word[31:16]` holds that quotient plus 2. `tune_en` is 1, and `ready` and `fail` are 0. Later changes of `clk_mhz` have no effect until the next `start`.
- R3: While waiting for lock, `lock` is sampled once every POLL_GAP cycles. The first sample is taken POLL_GAP cycles after `start` is accepted, or after a retry begins. If lock is not seen within POLL_LIMIT samples, the attempt fails.
- R4: After lock is first sampled high, `lock` is sampled on each of the next HOLD_LIMIT clocks. All of them must be high to qualify. Any low sample fails the attempt at once.
- R5: On qualification, `ready` goes to 1 and `tune_en` and `lim_word` bit 8 go to 0. The frequency fields are kept.
- R6: When an attempt fails and attempts remain, the limit word is rewritten with bit 8 cleared and `tune_en` 0. A new attempt begins with its poll spacing and sample count restarted.
- R7: When the MAX_TRIES-th attempt fails, `fail` goes to 1 and `ready` stays 0.
- R8: `ready` and `fail` are never both 1. Once set, each flag and `lim_word` hold steady regardless of `lock` until the next `start`.
- R9: A `start` arriving in any state abandons the current run and begins a fresh one exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin calibration |
| lock | input | 1 | Lock indicator from the PLL |
| clk_mhz | input | MHZ_W | Host clock rate in MHz, sampled at start |
| lim_word | output | 2*LIM_W | Limit word: high limit in the upper half, low limit in the lower half, tuning enable at bit 8 |
| tune_en | output | 1 | Tuning enable, the same value as `lim_word` bit 8 |
| ready | output | 1 | PLL qualified, held until the next start |
| fail | output | 1 | All attempts exhausted, held until the next start |

## Verification
A wrong poll spacing or sample count inside the controller shows up at the ports within one poll interval. It appears as `tune_en` falling too early or too late, or as `ready` rising a clock off. A corrupted qualification count makes `ready` rise one cycle early or late, or lets a late lock drop go unnoticed. A wrong attempt count moves the rise of `fail` by a whole attempt's length. Because these counts appear at the ports only as cycle timing, the reference model is compared against every output on every clock, so a fault is caught on the first cycle it reaches an output.

// File: rtl/pll_qual_pkg.sv
package pll_qual_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_HOLD,
    ST_DONE
  } qual_state_e;

  localparam int TUNE_BIT = 8;
  localparam int FREQ_NUM = 48;
  localparam int FREQ_DEN = 66;
  localparam int FREQ_MARGIN = 2;
endpackage

// File: rtl/pll_qual_limits.sv
module pll_qual_limits #(
  parameter int MHZ_W  = 8,
  parameter int LIM_W  = 16,
  parameter int NUM    = 48,
  parameter int DEN    = 66,
  parameter int MARGIN = 2
) (
  input  logic [MHZ_W-1:0] mhz,
  output logic [LIM_W-1:0] lo,
  output logic [LIM_W-1:0] hi
);
  localparam int PROD_W = MHZ_W + 8;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quo;

  always_comb begin
    prod = PROD_W'(mhz) * PROD_W'(NUM);
    quo  = prod / PROD_W'(DEN);
    lo   = LIM_W'(quo);
    hi   = LIM_W'(quo) + LIM_W'(MARGIN);
  end
endmodule

// File: rtl/pll_qual_pacer.sv
module pll_qual_pacer #(
  parameter int GAP = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [W-1:0] LAST = W'(GAP - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/pll_qual_count.sv
module pll_qual_count #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TOP);
endmodule

// File: rtl/pll_lock_qual.sv
module pll_lock_qual
  import pll_qual_pkg::*;
#(
  parameter int MHZ_W      = 8,
  parameter int LIM_W      = 16,
  parameter int POLL_GAP   = 50,
  parameter int POLL_LIMIT = 20480,
  parameter int HOLD_LIMIT = 4096,
  parameter int MAX_TRIES  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               lock,
  input  logic [MHZ_W-1:0]   clk_mhz,
  output logic [2*LIM_W-1:0] lim_word,
  output logic               tune_en,
  output logic               ready,
  output logic               fail
);
  qual_state_e state;
  logic [LIM_W-1:0] lo_calc, hi_calc, lo_q, hi_q;
  logic in_poll, in_hold, poll_tick;
  logic poll_last, hold_last, try_last;
  logic enter_hold, poll_miss, attempt_fail, retry, success;

  pll_qual_limits #(
    .MHZ_W(MHZ_W), .LIM_W(LIM_W), .NUM(FREQ_NUM), .DEN(FREQ_DEN), .MARGIN(FREQ_MARGIN)
  ) u_limits (
    .mhz(clk_mhz), .lo(lo_calc), .hi(hi_calc)
  );

  assign in_poll      = (state == ST_POLL);
  assign in_hold      = (state == ST_HOLD);
  assign enter_hold   = in_poll && poll_tick && lock;
  assign poll_miss    = in_poll && poll_tick && !lock;
  assign success      = in_hold && lock && hold_last;
  assign attempt_fail = (poll_miss && poll_last) || (in_hold && !lock);
  assign retry        = attempt_fail && !try_last;

  pll_qual_pacer #(.GAP(POLL_GAP)) u_pacer (
    .clk(clk), .rst(rst), .clear(start || retry), .run(in_poll), .tick(poll_tick)
  );

  pll_qual_count #(.LIMIT(POLL_LIMIT)) u_poll_cnt (
    .clk(clk), .rst(rst), .clear(start || retry), .inc(poll_miss), .last(poll_last)
  );

  pll_qual_count #(.LIMIT(HOLD_LIMIT)) u_hold_cnt (
    .clk(clk), .rst(rst), .clear(start || enter_hold), .inc(in_hold && lock), .last(hold_last)
  );

  pll_qual_count #(.LIMIT(MAX_TRIES)) u_try_cnt (
    .clk(clk), .rst(rst), .clear(start), .inc(attempt_fail), .last(try_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      tune_en <= 1'b0;
      ready   <= 1'b0;
      fail    <= 1'b0;
    end else if (start) begin
      state   <= ST_POLL;
      lo_q    <= lo_calc;
      hi_q    <= hi_calc;
      tune_en <= 1'b1;
      ready   <= 1'b0;
      fail    <= 1'b0;
    end else begin
      if (enter_hold) state <= ST_HOLD;
      if (success) begin
        state   <= ST_DONE;
        ready   <= 1'b1;
        tune_en <= 1'b0;
      end else if (attempt_fail) begin
        if (try_last) begin
          state <= ST_DONE;
          fail  <= 1'b1;
        end else begin
          state   <= ST_POLL;
          tune_en <= 1'b0;
        end
      end
    end
  end

  assign lim_word = {hi_q, lo_q | (LIM_W'(tune_en) << TUNE_BIT)};
endmodule

// File: rtl/pll_lock_qual_chk.sv
module pll_lock_qual_chk #(
  parameter int LIM_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               lock,
  input logic [2*LIM_W-1:0] lim_word,
  input logic               tune_en,
  input logic               ready,
  input logic               fail
);
  localparam logic [LIM_W-1:0] TUNE_MASK = ~(LIM_W'(1) << 8);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(ready && fail));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (tune_en && !ready && !fail));

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> ready);

  p_fail_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);

  p_ready_after_lock_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(lock));

  p_limit_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (lim_word != '0) |-> (lim_word[2*LIM_W-1:LIM_W] ==
                          (lim_word[LIM_W-1:0] & TUNE_MASK) + LIM_W'(2)));

  p_tune_only_running_r5: assert property (@(posedge clk) disable iff (rst)
    tune_en |-> (!ready && !fail));

  p_done_stable_r8: assert property (@(posedge clk) disable iff (rst)
    ((ready || fail) && !start) |=> $stable(lim_word));
endmodule

bind pll_lock_qual pll_lock_qual_chk i_chk (
  .clk(clk), .rst(rst), .start(start), .lock(lock), .lim_word(lim_word),
  .tune_en(tune_en), .ready(ready), .fail(fail)
);

// File: tb/test_pll_lock_qual.sv
module test_pll_lock_qual;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;
  localparam int PL  = 6;
  localparam int HL  = 5;
  localparam int TR  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic lock = 1'b0;
  logic [7:0] clk_mhz = 8'd0;
  logic [31:0] lim_word;
  logic tune_en, ready, fail;

  int checks = 0;
  int failures = 0;

  pll_lock_qual #(
    .POLL_GAP(GAP), .POLL_LIMIT(PL), .HOLD_LIMIT(HL), .MAX_TRIES(TR)
  ) i_pll_lock_qual (
    .clk(clk), .rst(rst), .start(start), .lock(lock), .clk_mhz(clk_mhz),
    .lim_word(lim_word), .tune_en(tune_en), .ready(ready), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_ph = 0, m_gap = 0, m_polls = 0, m_holds = 0, m_tries = 0;
  int m_lo = 0, m_hi = 0, m_tune = 0, m_rdy = 0, m_fl = 0;

  task automatic m_miss();
    m_tries++;
    if (m_tries == TR) begin m_ph = 3; m_fl = 1; end
    else begin m_tune = 0; m_ph = 1; m_gap = 0; m_polls = 0; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_lo = 0; m_hi = 0; m_tune = 0; m_rdy = 0; m_fl = 0;
    end else if (start) begin
      m_lo = int'(clk_mhz) * 48 / 66; m_hi = m_lo + 2;
      m_tune = 1; m_rdy = 0; m_fl = 0;
      m_ph = 1; m_gap = 0; m_polls = 0; m_tries = 0;
    end else if (m_ph == 1) begin
      m_gap++;
      if (m_gap == GAP) begin
        m_gap = 0;
        if (lock) begin m_ph = 2; m_holds = 0; end
        else begin m_polls++; if (m_polls == PL) m_miss(); end
      end
    end else if (m_ph == 2) begin
      if (!lock) m_miss();
      else begin
        m_holds++;
        if (m_holds == HL) begin m_ph = 3; m_rdy = 1; m_tune = 0; end
      end
    end
  end

  function automatic logic [31:0] word_of(int lo, int hi, int tune);
    return (32'(hi) << 16) | 32'(lo) | (32'(tune) << 8);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (lim_word !== word_of(m_lo, m_hi, m_tune)) begin
        failures++; $display("FAIL R2/R6 model lim_word act=%h exp=%h", lim_word, word_of(m_lo, m_hi, m_tune));
      end else if (ready !== m_rdy[0]) begin
        failures++; $display("FAIL R5 model ready act=%0b exp=%0b", ready, m_rdy[0]);
      end else if (fail !== m_fl[0]) begin
        failures++; $display("FAIL R7 model fail act=%0b exp=%0b", fail, m_fl[0]);
      end else if (tune_en !== m_tune[0]) begin
        failures++; $display("FAIL R6 model tune_en act=%0b exp=%0b", tune_en, m_tune[0]);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int mhz, int tune);
    int lo;
    lo = mhz * 48 / 66;
    return word_of(lo, lo + 2, tune);
  endfunction

  // lock high for on<=k<off, and again from k>=reon
  task automatic run(input int mhz, input int on, input int off, input int reon,
                     input int len, input int pk, input int ptune, input string tag);
    @(negedge clk);
    start = 1'b1; clk_mhz = 8'(mhz); lock = 1'b0;
    @(negedge clk);
    start = 1'b0;
    clk_mhz = 8'd0;
    check({tag, " R2 word after start"}, lim_word, exp_word(mhz, 1));
    check({tag, " R2 flags cleared"}, {30'd0, ready, fail}, 32'd0);
    for (int k = 0; k < len; k++) begin
      if (k == pk) check("R3 tune_en at probe", {31'd0, tune_en}, 32'(ptune));
      lock = ((k >= on) && (k < off)) || (k >= reon);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", lim_word, 32'd0);
    check("R1 reset flags", {29'd0, tune_en, ready, fail}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {29'd0, tune_en, ready, fail}, 32'd0);

    run(66, 2, 1000, 1000, 12, -1, 0, "R2");
    check("R5 ready after qualify", {30'd0, ready, fail}, 32'd2);
    check("R5 tuning cleared", lim_word, exp_word(66, 0));

    run(66, 2, 8, 1000, 14, -1, 0, "R4");
    check("R4 full hold window qualifies", {30'd0, ready, fail}, 32'd2);

    run(66, 2, 7, 1000, 60, 9, 0, "R4");
    check("R4 drop on last hold sample fails", {30'd0, ready, fail}, 32'd1);
    check("R6 limits rewritten untuned", lim_word, exp_word(66, 0));

    run(50, 2, 4, 12, 30, 8, 0, "R6");
    check("R6 retry then qualify", {30'd0, ready, fail}, 32'd2);
    check("R6 word after retry", lim_word, exp_word(50, 0));

    run(66, 17, 1000, 1000, 30, 18, 1, "R3");
    check("R3 lock on last poll sample", {30'd0, ready, fail}, 32'd2);
    run(66, 18, 1000, 1000, 30, 18, 0, "R3");
    check("R3 lock after poll budget retries", {30'd0, ready, fail}, 32'd2);

    run(33, 1000, 1000, 1000, 70, -1, 0, "R7");
    check("R7 all attempts failed", {30'd0, ready, fail}, 32'd1);

    lock = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 fail held under lock", {30'd0, ready, fail}, 32'd1);
    check("R8 word held", lim_word, exp_word(33, 0));

    run(66, 2, 1000, 1000, 4, -1, 0, "R9");
    run(50, 2, 1000, 1000, 12, -1, 0, "R9");
    check("R9 restart mid-hold qualifies new run", {30'd0, ready, fail}, 32'd2);
    check("R9 new limits", lim_word, exp_word(50, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements) act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule